// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around one accumulator. It walks every instruction through separate fetch, decode and execute states, and it talks to a single memory port that holds both the program and its data. Its visible state is a program counter and an address latch that drives the memory address. It also holds a data buffer that sits between memory and the core, an instruction holding register, the accumulator, an index register and a one-bit equality flag.

An instruction is one 16-bit word. Bits [15:10] hold the opcode and bits [9:0] hold the operand. Operands can be used in four ways: as a literal value, as a memory address, as the address of a pointer, or as a base to which the index register is added. Software can load and store, add and subtract, step a register up or down, compare, and branch on the flag. It can also wait for an input word, send out the accumulator with a strobe, and stop. Memory reads are synchronous: data requested in one cycle is returned on the next cycle.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, mem_rd, mem_wr, out_valid, in_ready and halted are all low. After reset is released, the first memory read goes to address 0.
- R2: Each instruction word is read from the address in the program counter, and the counter then advances by one. The opcode is word bits [15:10] and the operand is bits [9:0].
- R3: mem_rd and mem_wr are never high in the same cycle, and at most one access is made per cycle.
- R4: Opcodes with bit 5 set take the zero-extended operand as the value and make no data access. Opcode 1 loads the accumulator, 5 loads the index register, 40 adds, 41 subtracts and 44 compares.
- R5: Opcodes 2 (load), 8 (add), 9 (subtract) and 12 (compare) read memory at the operand address and use the word that comes back.
- R6: Opcode 3 (load) and opcode 13 (compare) each make two data reads. The first read is at the operand. The second read is at the low 10 bits of the word returned by the first read.
- R7: Opcode 4 loads the accumulator from address (operand + index register), modulo 1024.
- R8: Opcode 7 writes the accumulator to the operand address.
- R9: Arithmetic wraps modulo 2^16. Opcode 10 increments and opcode 11 decrements; operand bit 0 selects the target, 0 for the accumulator and 1 for the index register. Opcode 6 copies the accumulator into the index register.
- R10: A compare sets the flag when the accumulator equals the compared value and clears it otherwise. Opcode 14 always jumps to the operand. Opcode 15 jumps when the flag is set, and opcode 16 jumps when the flag is clear.
- R11: Opcode 17 raises in_ready and waits, leaving the accumulator unchanged, until in_valid is high. On the cycle where both are high, it loads in_data into the accumulator.
- R12: Opcode 18 drives the accumulator value on out_data with out_valid high for exactly one cycle.
- R13: Opcode 63 raises halted. The core then makes no further memory access, and only reset clears halted.
- R14: An opcode not listed above only advances the program counter and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 10 | Memory address, driven from the address latch |
| mem_rd | output | 1 | Read request; data returns on the next cycle |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| in_valid | input | 1 | Input word is available |
| in_ready | output | 1 | Core is waiting for an input word |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 16 | Output word |
| halted | output | 1 | Core has stopped |

## Verification
The hardest case to reach from the ports is the pointer access. It is the only path where a word that memory returns to the core goes back out as the next address. A fault in that path leaves the instruction fetches unchanged. The stimulus places a pointer word and its target in memory, then runs a program that uses the pointer twice: once to load and once to compare, with a branch taken on the result. The bench checks the order of the read addresses and the total number of reads, which exposes a missing or repeated second read.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W   = 6;
  localparam int unsigned IMM_BIT = 5;

  localparam logic [OPC_W-1:0] OPC_LDM = 6'd1;
  localparam logic [OPC_W-1:0] OPC_LDD = 6'd2;
  localparam logic [OPC_W-1:0] OPC_LDI = 6'd3;
  localparam logic [OPC_W-1:0] OPC_LDX = 6'd4;
  localparam logic [OPC_W-1:0] OPC_LDR = 6'd5;
  localparam logic [OPC_W-1:0] OPC_MOV = 6'd6;
  localparam logic [OPC_W-1:0] OPC_STO = 6'd7;
  localparam logic [OPC_W-1:0] OPC_ADD = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SUB = 6'd9;
  localparam logic [OPC_W-1:0] OPC_INC = 6'd10;
  localparam logic [OPC_W-1:0] OPC_DEC = 6'd11;
  localparam logic [OPC_W-1:0] OPC_CMP = 6'd12;
  localparam logic [OPC_W-1:0] OPC_CMI = 6'd13;
  localparam logic [OPC_W-1:0] OPC_JMP = 6'd14;
  localparam logic [OPC_W-1:0] OPC_JPE = 6'd15;
  localparam logic [OPC_W-1:0] OPC_JPN = 6'd16;
  localparam logic [OPC_W-1:0] OPC_IN  = 6'd17;
  localparam logic [OPC_W-1:0] OPC_OUT = 6'd18;
  localparam logic [OPC_W-1:0] OPC_END = 6'd63;

  typedef enum logic [3:0] {
    ST_F_ADDR, ST_F_READ, ST_F_CAPT, ST_F_LOAD, ST_DECODE,
    ST_D_READ, ST_D_CAPT, ST_D_PTR, ST_D_EXEC, ST_D_WRITE,
    ST_IN_WAIT, ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    K_NOP, K_ALU_IMM, K_LDR, K_MOV, K_INC, K_DEC, K_JMP, K_JPE,
    K_JPN, K_IN, K_OUT, K_END, K_MEM
  } kind_e;

  typedef enum logic [1:0] { A_PASS, A_ADD, A_SUB, A_CMP } alu_op_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e alu;
    logic    indirect;
    logic    indexed;
    logic    store;
  } dec_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  logic [OPC_W-1:0] base_opc;
  logic             imm_mode;

  assign imm_mode = opc[IMM_BIT];
  assign base_opc = opc & ~(OPC_W'(1) << IMM_BIT);

  always_comb begin
    dec.kind     = K_NOP;
    dec.alu      = A_PASS;
    dec.indirect = 1'b0;
    dec.indexed  = 1'b0;
    dec.store    = 1'b0;
    if (opc == OPC_END) begin
      dec.kind = K_END;
    end else if (imm_mode) begin
      // immediate forms of the arithmetic and compare group
      case (base_opc)
        OPC_ADD: begin dec.kind = K_ALU_IMM; dec.alu = A_ADD; end
        OPC_SUB: begin dec.kind = K_ALU_IMM; dec.alu = A_SUB; end
        OPC_CMP: begin dec.kind = K_ALU_IMM; dec.alu = A_CMP; end
        default: dec.kind = K_NOP;
      endcase
    end else begin
      case (opc)
        OPC_LDM: begin dec.kind = K_ALU_IMM; dec.alu = A_PASS; end
        OPC_LDD: begin dec.kind = K_MEM; dec.alu = A_PASS; end
        OPC_LDI: begin dec.kind = K_MEM; dec.alu = A_PASS; dec.indirect = 1'b1; end
        OPC_LDX: begin dec.kind = K_MEM; dec.alu = A_PASS; dec.indexed = 1'b1; end
        OPC_LDR: dec.kind = K_LDR;
        OPC_MOV: dec.kind = K_MOV;
        OPC_STO: begin dec.kind = K_MEM; dec.store = 1'b1; end
        OPC_ADD: begin dec.kind = K_MEM; dec.alu = A_ADD; end
        OPC_SUB: begin dec.kind = K_MEM; dec.alu = A_SUB; end
        OPC_INC: dec.kind = K_INC;
        OPC_DEC: dec.kind = K_DEC;
        OPC_CMP: begin dec.kind = K_MEM; dec.alu = A_CMP; end
        OPC_CMI: begin dec.kind = K_MEM; dec.alu = A_CMP; dec.indirect = 1'b1; end
        OPC_JMP: dec.kind = K_JMP;
        OPC_JPE: dec.kind = K_JPE;
        OPC_JPN: dec.kind = K_JPN;
        OPC_IN:  dec.kind = K_IN;
        OPC_OUT: dec.kind = K_OUT;
        default: dec.kind = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         equal,
  output logic         acc_we
);

  function automatic logic [W-1:0] f_wrap_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] f_wrap_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + (~y) + W'(1);
  endfunction

  always_comb begin
    case (op)
      A_ADD:   result = f_wrap_add(a, b);
      A_SUB:   result = f_wrap_sub(a, b);
      A_PASS:  result = b;
      default: result = a;
    endcase
  end

  assign equal  = (a == b);
  assign acc_we = (op != A_CMP);

endmodule

// File: rtl/acc_cpu_ea.sv
module acc_cpu_ea #(
  parameter int unsigned AW = 10
) (
  input  logic          use_index,
  input  logic [AW-1:0] arg,
  input  logic [AW-1:0] ix_low,
  output logic [AW-1:0] ea
);

  function automatic logic [AW-1:0] f_index(input logic [AW-1:0] base, input logic [AW-1:0] off);
    return base + off;
  endfunction

  assign ea = use_index ? f_index(arg, ix_low) : arg;

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [DATA_W-OPC_W-1:0]    mem_addr,
  output logic                       mem_rd,
  output logic                       mem_wr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_data,
  output logic                       halted
);

  localparam int unsigned AW = DATA_W - OPC_W;

  state_e            state;
  logic [AW-1:0]     pc;
  logic [AW-1:0]     mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] cir;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] ix;
  logic              flag;
  logic              ind_pend;
  logic              out_v;
  logic [DATA_W-1:0] out_d;

  // instruction fields
  logic [OPC_W-1:0]  opc;
  logic [AW-1:0]     arg;
  logic [DATA_W-1:0] imm_ext;
  dec_t              dec;

  assign opc     = cir[DATA_W-1 -: OPC_W];
  assign arg     = cir[AW-1:0];
  assign imm_ext = DATA_W'(arg);

  acc_cpu_decode u_decode (
    .opc (opc),
    .dec (dec)
  );

  // effective address generation
  logic [AW-1:0] ea;

  acc_cpu_ea #(.AW(AW)) u_ea (
    .use_index (dec.indexed),
    .arg       (arg),
    .ix_low    (ix[AW-1:0]),
    .ea        (ea)
  );

  // arithmetic unit: operand comes from memory in the execute state
  logic              exec_from_mem;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_res;
  logic              alu_eq;
  logic              alu_acc_we;

  assign exec_from_mem = (state == ST_D_EXEC);
  assign alu_b         = exec_from_mem ? mdr : imm_ext;

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .op     (dec.alu),
    .a      (acc),
    .b      (alu_b),
    .result (alu_res),
    .equal  (alu_eq),
    .acc_we (alu_acc_we)
  );

  // named events for assertions
  logic fetch_rd;
  logic data_rd;
  logic store_wr;
  logic in_xfer;
  logic exec_now;

  assign fetch_rd = (state == ST_F_READ);
  assign data_rd  = (state == ST_D_READ);
  assign store_wr = (state == ST_D_WRITE);
  assign in_xfer  = (state == ST_IN_WAIT) && in_valid;
  assign exec_now = exec_from_mem || ((state == ST_DECODE) && (dec.kind == K_ALU_IMM));

  // bus outputs
  assign mem_addr  = mar;
  assign mem_rd    = fetch_rd || data_rd;
  assign mem_wr    = store_wr;
  assign mem_wdata = mdr;
  assign in_ready  = (state == ST_IN_WAIT);
  assign out_valid = out_v;
  assign out_data  = out_d;
  assign halted    = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_F_ADDR;
      pc       <= '0;
      mar      <= '0;
      mdr      <= '0;
      cir      <= '0;
      acc      <= '0;
      ix       <= '0;
      flag     <= 1'b0;
      ind_pend <= 1'b0;
      out_v    <= 1'b0;
      out_d    <= '0;
    end else begin
      out_v <= 1'b0;
      if (exec_now) begin
        if (alu_acc_we) acc  <= alu_res;
        else            flag <= alu_eq;
      end
      case (state)
        ST_F_ADDR: begin
          mar   <= pc;
          state <= ST_F_READ;
        end
        ST_F_READ: state <= ST_F_CAPT;
        ST_F_CAPT: begin
          mdr   <= mem_rdata;
          state <= ST_F_LOAD;
        end
        ST_F_LOAD: begin
          cir   <= mdr;
          pc    <= pc + AW'(1);
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          state <= ST_F_ADDR;
          case (dec.kind)
            K_LDR: ix <= imm_ext;
            K_MOV: ix <= acc;
            K_INC: begin
              if (arg[0]) ix  <= ix + DATA_W'(1);
              else        acc <= acc + DATA_W'(1);
            end
            K_DEC: begin
              if (arg[0]) ix  <= ix - DATA_W'(1);
              else        acc <= acc - DATA_W'(1);
            end
            K_JMP: pc <= arg;
            K_JPE: if (flag)  pc <= arg;
            K_JPN: if (!flag) pc <= arg;
            K_IN:  state <= ST_IN_WAIT;
            K_OUT: begin
              out_v <= 1'b1;
              out_d <= acc;
            end
            K_END: state <= ST_HALT;
            K_MEM: begin
              mar      <= ea;
              ind_pend <= dec.indirect;
              if (dec.store) begin
                mdr   <= acc;
                state <= ST_D_WRITE;
              end else begin
                state <= ST_D_READ;
              end
            end
            default: state <= ST_F_ADDR;
          endcase
        end
        ST_D_READ: state <= ST_D_CAPT;
        ST_D_CAPT: begin
          mdr <= mem_rdata;
          if (ind_pend) begin
            ind_pend <= 1'b0;
            state    <= ST_D_PTR;
          end else begin
            state <= ST_D_EXEC;
          end
        end
        ST_D_PTR: begin
          mar   <= mdr[AW-1:0];
          state <= ST_D_READ;
        end
        ST_D_EXEC:  state <= ST_F_ADDR;
        ST_D_WRITE: state <= ST_F_ADDR;
        ST_IN_WAIT: begin
          if (in_valid) begin
            acc   <= in_data;
            state <= ST_F_ADDR;
          end
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_F_ADDR;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_fetch_at_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rd |-> (mem_addr == pc));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F_LOAD) |=> (pc == $past(pc) + AW'(1)));

  p_store_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == acc));

  p_out_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_halt_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr));

  p_in_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(acc) && in_ready));

  p_in_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_xfer |=> (acc == $past(in_data)));

endmodule

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

  localparam int DW = 16;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          halted;

  always #4 clk = ~clk;

  acc_cpu_core #(.DATA_W(DW)) i_acc_cpu_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .halted(halted)
  );

  logic [DW-1:0] mem [1024];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt, both_cnt, out_cnt;
  logic [AW-1:0] rd_log [64];
  logic [DW-1:0] out_log [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
      if (mem_rd && mem_wr) both_cnt++;
      if (out_valid) begin
        if (out_cnt < 16) out_log[out_cnt] = out_data;
        out_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [DW-1:0] ins(input logic [5:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rd_cnt = 0; both_cnt = 0; out_cnt = 0;
  endtask

  task automatic run_halt(input string req, input int limit);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk(req, halted, 1);
  endtask

  // vector: {opcode, value A at 100, value B, expected output}
  localparam logic [53:0] VEC [7] = '{
    {6'd8,  16'd5,     16'd3,     16'd8},
    {6'd8,  16'hFFFF,  16'd2,     16'd1},
    {6'd9,  16'd10,    16'd3,     16'd7},
    {6'd9,  16'd0,     16'd1,     16'hFFFF},
    {6'd2,  16'd7,     16'h1234,  16'h1234},
    {6'd40, 16'd1000,  16'd300,   16'd1300},
    {6'd41, 16'd5,     16'd6,     16'hFFFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    hold_reset();
    repeat (2) @(negedge clk);
    chk("R1 mem_rd in reset", mem_rd, 0);
    chk("R1 mem_wr in reset", mem_wr, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 0);
    chk("R1 halted in reset", halted, 0);

    // table of arithmetic vectors: R2 R4 R5 R9
    for (int k = 0; k < 7; k++) begin
      logic [5:0]  op;
      logic [15:0] va, vb, ve;
      {op, va, vb, ve} = VEC[k];
      hold_reset();
      mem[100] = va;
      mem[101] = vb;
      mem[0] = ins(6'd2, 10'd100);
      mem[1] = op[5] ? ins(op, vb[9:0]) : ins(op, 10'd101);
      mem[2] = ins(6'd18, 10'd0);
      mem[3] = ins(6'd63, 10'd0);
      run_halt("R13 vector halt", 500);
      chk("R9 vector output count", out_cnt, 1);
      chk("R5 R4 R9 vector result", out_log[0], ve);
      chk("R4 R5 read count", rd_cnt, op[5] ? 5 : 6);
      chk("R1 first read at 0", rd_log[0], 0);
      chk("R5 direct read address", rd_log[1], 100);
      chk("R2 second fetch at 1", rd_log[2], 1);
    end

    // R6: indirect load and compare, JPE taken
    hold_reset();
    mem[200] = 16'd210;
    mem[210] = 16'h0ABC;
    mem[0] = ins(6'd3, 10'd200);
    mem[1] = ins(6'd18, 10'd0);
    mem[2] = ins(6'd13, 10'd200);
    mem[3] = ins(6'd15, 10'd6);
    mem[4] = ins(6'd1, 10'd1);
    mem[5] = ins(6'd18, 10'd0);
    mem[6] = ins(6'd1, 10'd2);
    mem[7] = ins(6'd18, 10'd0);
    mem[8] = ins(6'd63, 10'd0);
    run_halt("R6 halt", 1000);
    chk("R6 outputs", out_cnt, 2);
    chk("R6 indirect load value", out_log[0], 16'h0ABC);
    chk("R10 JPE taken after CMI", out_log[1], 16'd2);
    chk("R6 pointer read", rd_log[1], 200);
    chk("R6 target read", rd_log[2], 210);
    chk("R6 total reads", rd_cnt, 11);

    // R7 R8 R9: index, store, inc, mov, dec
    hold_reset();
    mem[303] = 16'h0055;
    mem[87]  = 16'h7777;
    mem[0] = ins(6'd5, 10'd3);
    mem[1] = ins(6'd4, 10'd300);
    mem[2] = ins(6'd10, 10'd0);
    mem[3] = ins(6'd7, 10'd400);
    mem[4] = ins(6'd6, 10'd0);
    mem[5] = ins(6'd10, 10'd1);
    mem[6] = ins(6'd4, 10'd0);
    mem[7] = ins(6'd11, 10'd0);
    mem[8] = ins(6'd18, 10'd0);
    mem[9] = ins(6'd63, 10'd0);
    run_halt("R7 halt", 1000);
    chk("R8 store value", mem[400], 16'h0056);
    chk("R7 R9 indexed after MOV/INC IX and DEC", out_log[0], 16'h7776);
    chk("R7 read count", rd_cnt, 12);
    chk("R3 no overlapping access", both_cnt, 0);

    // R10: compare and conditional jumps
    hold_reset();
    mem[100] = 16'd5;
    mem[0]  = ins(6'd1, 10'd5);
    mem[1]  = ins(6'd44, 10'd6);
    mem[2]  = ins(6'd15, 10'd10);
    mem[3]  = ins(6'd16, 10'd5);
    mem[4]  = ins(6'd63, 10'd0);
    mem[5]  = ins(6'd12, 10'd100);
    mem[6]  = ins(6'd16, 10'd10);
    mem[7]  = ins(6'd14, 10'd12);
    mem[8]  = ins(6'd63, 10'd0);
    mem[10] = ins(6'd1, 10'd99);
    mem[11] = ins(6'd18, 10'd0);
    mem[12] = ins(6'd1, 10'd7);
    mem[13] = ins(6'd18, 10'd0);
    mem[14] = ins(6'd63, 10'd0);
    run_halt("R10 halt", 1000);
    chk("R10 branch path outputs", out_cnt, 1);
    chk("R10 branch path value", out_log[0], 16'd7);

    // R11 R12: input wait and output strobe
    hold_reset();
    mem[0] = ins(6'd17, 10'd0);
    mem[1] = ins(6'd18, 10'd0);
    mem[2] = ins(6'd63, 10'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (in_ready) break;
    end
    chk("R11 in_ready raised", in_ready, 1);
    repeat (10) @(negedge clk);
    chk("R11 still waiting", in_ready, 1);
    chk("R11 no output while waiting", out_cnt, 0);
    in_valid = 1'b1;
    in_data = 16'hBEEF;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 ready drops after transfer", in_ready, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk("R12 single strobe", out_cnt, 1);
    chk("R12 output value", out_log[0], 16'hBEEF);

    // R13 R14: unknown opcode and halt
    hold_reset();
    mem[0] = ins(6'd1, 10'd33);
    mem[1] = ins(6'd20, 10'd5);
    mem[2] = ins(6'd18, 10'd0);
    mem[3] = ins(6'd63, 10'd0);
    mem[4] = ins(6'd1, 10'd1);
    mem[5] = ins(6'd18, 10'd0);
    run_halt("R13 halt", 500);
    chk("R14 unknown opcode leaves acc", out_log[0], 16'd33);
    begin
      int rd_at_halt;
      rd_at_halt = rd_cnt;
      repeat (40) @(negedge clk);
      chk("R13 no reads after halt", rd_cnt, rd_at_halt);
      chk("R13 halted held", halted, 1);
      chk("R13 no output after halt", out_cnt, 1);
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 R13 reset clears halted", halted, 0);

    summary();
    $finish;
  end

endmodule